// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block watches a single-bit infrared receiver line and turns it into a compact stream of one-byte run-length codes. The line passes through a synchronizer. It is sampled once every `DIV` clocks, which gives an 8 us sample period from an 8 MHz base clock with the default `DIV` of 64. An optional polarity flip lets an active-low receiver report its bursts as level 1. A glitch filter then removes level changes shorter than a programmable number of samples.

Each stretch of constant filtered level becomes one or more codes. Bit 7 of a code holds the level, and bits 6:0 hold the run length in samples minus one. A packet opens at the first filtered pulse sample. It closes when the line has stayed at level 0 for the idle threshold. At that point the trailing space is flushed as a code and a one-cycle packet-end strobe is raised. A downstream FIFO or host logic takes a byte on each cycle where `code_valid` is high, and it uses `pkt_end` to start protocol decoding.

Top module: `ir_runlen_sampler`

## Requirements
- R1: A code is a byte: bit 7 is the run's filtered level (1 = pulse), and bits 6:0 are the run length in samples minus one. A run is emitted as a code on the sample where the level changes.
- R2: The synchronized input is sampled once every `DIV` clock cycles. A run held for n sample periods therefore reports a length of n samples.
- R3: When `invert` is 1, the sampled level is the complement of `ir_raw`. A low-active line then yields pulse codes with bit 7 set.
- R4: A change of filtered level needs `noise_thr` consecutive samples at the new level. A value of 0 acts as 1. Shorter glitches are absorbed into the surrounding run, and the total run lengths are preserved.
- R5: A run longer than 128 samples is split. Each complete 128-sample part is emitted as a code with bits 6:0 = 0x7F (0xFF for pulses), and the remainder follows as a final code.
- R6: Outside a packet, level-0 samples produce no code. A packet opens on the first filtered level-1 sample.
- R7: Inside a packet, the packet is closed on the N-th consecutive space sample, where N = max(`idle_thr`, 2). That sample emits a space code covering all N samples, and `pkt_end` is raised in the same cycle. No further code follows until the next pulse.
- R8: If the closing space would exceed 128 samples since the last space code, the closing code saturates at 0x7F and no separate split code is emitted. For example, with `idle_thr` = 129 the single output is 0x7F together with `pkt_end`.
- R9: Sampling happens only while `glb_en` and `rx_en` are both 1 and `mode_sel` equals 3. Otherwise there is no output, and the divider, the filter and the packet state are cleared.
- R10: `code_valid` and `pkt_end` are single-cycle pulses. `pkt_end` is only ever raised together with a level-0 code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_raw | input | 1 | Asynchronous infrared receiver line |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode_sel | input | 2 | Operating mode; 3 selects run-length sampling |
| invert | input | 1 | Flip input polarity before sampling |
| noise_thr | input | 6 | Minimum accepted run, in samples |
| idle_thr | input | 8 | Space length that closes a packet, in samples |
| code_valid | output | 1 | Code byte strobe |
| code_data | output | 8 | Level bit and length-minus-one field |
| pkt_end | output | 1 | Packet closed on this cycle |

## Verification
Two events can land on the same sample. A run can reach its 128-sample split point on exactly the sample where the idle timeout fires. Separately, the timeout flush always shares its cycle with the packet-end strobe. The first collision is provoked by setting `idle_thr` to 129 after a short pulse. The bench then expects a single 0x7F code with `pkt_end` in the same cycle and no extra split code. The scoreboard queues each code followed by a packet-end marker, so both outputs of that cycle are compared in order.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

    localparam int unsigned LEN_W = 7;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [1:0] MODE_RUNLEN = 2'b11;

    typedef struct packed {
        logic             level;
        logic [LEN_W-1:0] len_m1;
    } rl_code_t;

    function automatic logic [LEN_W-1:0] len_bump(input logic [LEN_W-1:0] v);
        return (v == LEN_MAX) ? LEN_MAX : v + 1'b1;
    endfunction

endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ir_rl_ticker.sv
module ir_rl_ticker #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_rl_filter.sv
module ir_rl_filter #(
    parameter int unsigned THR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             smp,
    input  logic [THR_W-1:0] thr,
    output logic             f_valid,
    output logic             f_level
);
    logic [THR_W-1:0] cnt;
    logic [THR_W:0]   cnt_nx;
    logic [THR_W:0]   thr_eff;

    always_comb begin
        cnt_nx  = {1'b0, cnt} + 1'b1;
        thr_eff = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            f_level <= 1'b0;
            f_valid <= 1'b0;
        end else begin
            f_valid <= tick;
            if (tick) begin
                if (smp == f_level) begin
                    cnt <= '0;
                end else if (cnt_nx >= thr_eff) begin
                    f_level <= smp;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt_nx[THR_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/ir_rl_encoder.sv
module ir_rl_encoder
    import ir_rl_pkg::*;
#(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              s_valid,
    input  logic              s_level,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              code_valid,
    output rl_code_t          code,
    output logic              pkt_end
);
    logic             in_pkt;
    logic             cur;
    logic [LEN_W-1:0] len;
    logic [IDLE_W-1:0] zcnt;
    logic [IDLE_W-1:0] zcnt_inc;
    logic              timeout;

    always_comb begin
        zcnt_inc = (zcnt == '1) ? zcnt : zcnt + 1'b1;
        timeout  = in_pkt && !cur && !s_level && (zcnt_inc >= idle_thr);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            in_pkt     <= 1'b0;
            cur        <= 1'b0;
            len        <= '0;
            zcnt       <= '0;
            code_valid <= 1'b0;
            code       <= '0;
            pkt_end    <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            pkt_end    <= 1'b0;
            if (s_valid) begin
                if (!in_pkt) begin
                    if (s_level) begin
                        in_pkt <= 1'b1;
                        cur    <= 1'b1;
                        len    <= '0;
                        zcnt   <= '0;
                    end
                end else if (s_level != cur) begin
                    code_valid <= 1'b1;
                    code       <= '{level: cur, len_m1: len};
                    cur        <= s_level;
                    len        <= '0;
                    zcnt       <= s_level ? '0 : IDLE_W'(1);
                end else if (timeout) begin
                    code_valid <= 1'b1;
                    code       <= '{level: 1'b0, len_m1: len_bump(len)};
                    pkt_end    <= 1'b1;
                    in_pkt     <= 1'b0;
                    len        <= '0;
                    zcnt       <= '0;
                end else if (len == LEN_MAX) begin
                    code_valid <= 1'b1;
                    code       <= '{level: cur, len_m1: LEN_MAX};
                    len        <= '0;
                    if (!cur) zcnt <= zcnt_inc;
                end else begin
                    len <= len + 1'b1;
                    if (!cur) zcnt <= zcnt_inc;
                end
            end
        end
    end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int unsigned DIV         = 64,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned NOISE_W     = 6,
    parameter int unsigned IDLE_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ir_raw,
    input  logic               glb_en,
    input  logic               rx_en,
    input  logic [1:0]         mode_sel,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    output logic               code_valid,
    output logic [7:0]         code_data,
    output logic               pkt_end
);
    logic     active;
    logic     line_sync;
    logic     smp;
    logic     tick;
    logic     f_valid;
    logic     f_level;
    rl_code_t code;

    assign active = glb_en && rx_en && (mode_sel == MODE_RUNLEN);
    assign smp    = line_sync ^ invert;

    ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(ir_raw), .dout(line_sync)
    );

    ir_rl_ticker #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .run(active), .tick(tick)
    );

    ir_rl_filter #(.THR_W(NOISE_W)) u_filt (
        .clk(clk), .rst(rst), .run(active), .tick(tick), .smp(smp),
        .thr(noise_thr), .f_valid(f_valid), .f_level(f_level)
    );

    ir_rl_encoder #(.IDLE_W(IDLE_W)) u_enc (
        .clk(clk), .rst(rst), .run(active), .s_valid(f_valid),
        .s_level(f_level), .idle_thr(idle_thr),
        .code_valid(code_valid), .code(code), .pkt_end(pkt_end)
    );

    assign code_data = code;
endmodule

// File: rtl/ir_runlen_sampler_chk.sv
module ir_runlen_sampler_chk (
    input logic       clk,
    input logic       rst,
    input logic       glb_en,
    input logic       rx_en,
    input logic [1:0] mode_sel,
    input logic       code_valid,
    input logic [7:0] code_data,
    input logic       pkt_end
);
    // R9
    off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !(glb_en && rx_en && mode_sel == 2'b11) |=> !code_valid && !pkt_end);

    // R10
    code_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> !pkt_end);

    // R7
    end_with_space_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> code_valid && !code_data[7]);
endmodule

bind ir_runlen_sampler ir_runlen_sampler_chk u_chk (
    .clk(clk), .rst(rst), .glb_en(glb_en), .rx_en(rx_en),
    .mode_sel(mode_sel), .code_valid(code_valid),
    .code_data(code_data), .pkt_end(pkt_end)
);

// File: tb/ir_runlen_sampler_tb.sv
module ir_runlen_sampler_tb;
    localparam int DIV = 64;
    localparam logic [8:0] END_MARK = 9'h100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_raw = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic       invert = 1'b0;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd20;
    logic       code_valid;
    logic [7:0] code_data;
    logic       pkt_end;

    int checks = 0;
    int fails  = 0;
    int spurious = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ir_runlen_sampler u_dut (
        .clk(clk), .rst(rst), .ir_raw(ir_raw), .glb_en(glb_en), .rx_en(rx_en),
        .mode_sel(mode_sel), .invert(invert), .noise_thr(noise_thr),
        .idle_thr(idle_thr), .code_valid(code_valid), .code_data(code_data),
        .pkt_end(pkt_end)
    );

    task automatic expect_item(input logic [8:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_raw = lvl;
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic judge(input logic [8:0] got);
        logic [8:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            spurious++;
            $display("FAIL unexpected output: actual %h expected none", got);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (got !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, got, e);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (code_valid) judge({1'b0, code_data});
            if (pkt_end)    judge(END_MARK);
        end
    end

    task automatic enable_all();
        @(negedge clk);
        glb_en = 1'b1; rx_en = 1'b1; mode_sel = 2'b11;
    endtask

    task automatic disable_all();
        @(negedge clk);
        glb_en = 1'b0; rx_en = 1'b0;
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d items pending expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (code_valid !== 1'b0 || pkt_end !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: actual %b%b expected 00", code_valid, pkt_end);
        end

        // R1 R2 R6 R7: basic packet
        enable_all();
        hold(0, 5);
        expect_item(9'h089, "R1");
        expect_item(9'h004, "R1");
        expect_item(9'h082, "R2");
        expect_item(9'h013, "R7");
        expect_item(END_MARK, "R7");
        hold(1, 10); hold(0, 5); hold(1, 3); hold(0, 30);
        check_drained("R7");

        // R5: long pulse split
        expect_item(9'h0FF, "R5");
        expect_item(9'h0FF, "R5");
        expect_item(9'h0AB, "R5");
        expect_item(9'h013, "R5");
        expect_item(END_MARK, "R5");
        hold(1, 300); hold(0, 25);
        check_drained("R5");

        // R4: glitch filter with threshold 3
        noise_thr = 6'd3;
        hold(1, 2); hold(0, 10);
        expect_item(9'h095, "R4");
        expect_item(9'h013, "R4");
        expect_item(END_MARK, "R4");
        hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 30);
        check_drained("R4");
        noise_thr = 6'd1;

        // R3: inverted line
        disable_all();
        ir_raw = 1'b1;
        invert = 1'b1;
        enable_all();
        hold(1, 5);
        expect_item(9'h084, "R3");
        expect_item(9'h013, "R3");
        expect_item(END_MARK, "R3");
        hold(0, 5); hold(1, 25);
        check_drained("R3");
        disable_all();
        invert = 1'b0;
        ir_raw = 1'b0;

        // R9: disabled states produce nothing
        hold(1, 10); hold(0, 30);
        @(negedge clk);
        glb_en = 1'b1; rx_en = 1'b1; mode_sel = 2'b10;
        hold(1, 10); hold(0, 30);
        checks++;
        if (spurious != 0) begin
            fails++;
            $display("FAIL R9: actual %0d outputs expected 0", spurious);
        end
        enable_all();
        hold(0, 3);

        // R8: timeout coincides with split point
        idle_thr = 8'd129;
        expect_item(9'h083, "R8");
        expect_item(9'h07F, "R8");
        expect_item(END_MARK, "R8");
        hold(1, 4); hold(0, 140);
        check_drained("R8");

        // R7: minimum effective idle threshold of two samples
        idle_thr = 8'd1;
        expect_item(9'h082, "R7");
        expect_item(9'h001, "R7");
        expect_item(END_MARK, "R7");
        hold(1, 3); hold(0, 5);
        check_drained("R7");

        // R6: space-only activity after packet end gives nothing
        hold(0, 10);
        check_drained("R6");
        checks++;
        if (spurious != 0) begin
            fails++;
            $display("FAIL R6: actual %0d outputs expected 0", spurious);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule